// File: doc/BRIEF.md
# Branch Target Buffer Predictor

This block sits beside the fetch stage and predicts the next fetch address. Fetch presents the address of a branch and its kind: conditional, unconditional jump, call or return. In the same cycle the block answers with a hit flag, a taken/not-taken direction and a target address. Jumps, calls and conditional branches are looked up in a direct-mapped target table. Each entry holds a valid bit, an address tag, the last taken target and a two-bit saturating history counter. Returns take their target from a separate circular return-address stack. Each call pushes its fall-through address onto that stack. A conditional branch with no table entry is predicted not taken.

When a branch resolves in execute, the resolution port receives the actual outcome and the prediction that was made for it. The block then trains or allocates the table entry and raises a combinational mispredict flag. A small sequencer (states `FL_IDLE` and `FL_DRAIN`) goes from `FL_IDLE` to `FL_DRAIN` on a mispredict. It stays in `FL_DRAIN` for a fixed five-cycle penalty and restarts the count on any further mispredict. It then returns to `FL_IDLE`. While it drains, the lookup port gives no prediction and leaves the stack untouched.

Top module: `bpred_top`

## Requirements
- R1: After reset every table entry is invalid, the return stack is empty and `flush_busy` is low, so every lookup gives `pred_hit`=0 and `pred_taken`=0.
- R2: A conditional branch (`lk_kind`=2'b00) that misses in the table is predicted not taken, and `pred_target` is zero.
- R3: A taken resolution of an address that misses allocates an entry in the weakly-taken state with the resolved target. A later conditional lookup then hits and predicts taken to that target, and a single not-taken resolution flips it to not taken.
- R4: The history counter saturates at both ends (0 strongly not-taken … 3 strongly taken). A conditional lookup predicts taken when the counter is 2 or 3.
- R5: A jump (2'b01) or call (2'b10) that hits is predicted taken to the stored target, whatever the counter holds.
- R6: The table index is the low log2(entries) address bits and the tag is the rest. An address that shares an index with a stored entry but has a different tag misses.
- R7: A not-taken resolution of an address that misses allocates nothing.
- R8: `mispredict` is high in the resolution cycle when the actual direction differs from the predicted one, or when both are taken and the targets differ. It is low otherwise.
- R9: `flush_busy` is high for exactly five cycles, starting the cycle after a mispredict. During that time lookups give no prediction and do not push or pop the return stack.
- R10: A call lookup pushes `lk_next_pc`. A return (2'b11) lookup pops the most recent entry and predicts taken to it, in last-in first-out order, and never reports `pred_hit`.
- R11: When the stack is full, a push overwrites the oldest entry. A return lookup on an empty stack predicts not taken.
- R12: When a resolution writes the entry that a lookup reads in the same cycle, the lookup reflects the entry as written.
- R13: A taken resolution that hits with a new target replaces the stored target.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request |
| lk_pc | input | ADDR_W | Branch address to look up |
| lk_kind | input | 2 | Branch kind: 00 cond, 01 jump, 10 call, 11 return |
| lk_next_pc | input | ADDR_W | Fall-through address, pushed on a call |
| pred_hit | output | 1 | Table hit |
| pred_taken | output | 1 | Predicted taken |
| pred_target | output | ADDR_W | Predicted target, zero when not taken |
| up_valid | input | 1 | Resolution valid |
| up_pc | input | ADDR_W | Resolved branch address |
| up_kind | input | 2 | Resolved branch kind |
| up_taken | input | 1 | Actual direction |
| up_target | input | ADDR_W | Actual target |
| up_pred_taken | input | 1 | Direction that was predicted |
| up_pred_target | input | ADDR_W | Target that was predicted |
| mispredict | output | 1 | Prediction was wrong |
| flush_busy | output | 1 | Five-cycle misprediction penalty in progress |

## Verification
The bench builds the block with a 16-bit address, a 16-entry table and a 4-deep return stack. With a 4-bit index, tag aliasing can be shown with two short addresses. Five calls are enough to overflow the stack and see the oldest entry dropped. The flush length keeps its default of five, so the penalty window is measured cycle by cycle against the stated figure.

// File: rtl/bpred_pkg.sv
package bpred_pkg;

    typedef enum logic [1:0] {
        BK_COND = 2'b00,
        BK_JUMP = 2'b01,
        BK_CALL = 2'b10,
        BK_RET  = 2'b11
    } br_kind_e;

    typedef enum logic [1:0] {
        CT_STRONG_NT = 2'd0,
        CT_WEAK_NT   = 2'd1,
        CT_WEAK_T    = 2'd2,
        CT_STRONG_T  = 2'd3
    } ctr_e;

    typedef enum logic {
        FL_IDLE  = 1'b0,
        FL_DRAIN = 1'b1
    } flush_state_e;

    // Saturating step of the four-state history counter
    function automatic ctr_e ctr_step(input ctr_e c, input logic taken);
        ctr_e r;
        unique case (c)
            CT_STRONG_NT: r = taken ? CT_WEAK_NT  : CT_STRONG_NT;
            CT_WEAK_NT:   r = taken ? CT_WEAK_T   : CT_STRONG_NT;
            CT_WEAK_T:    r = taken ? CT_STRONG_T : CT_WEAK_NT;
            CT_STRONG_T:  r = taken ? CT_STRONG_T : CT_WEAK_T;
        endcase
        return r;
    endfunction

    function automatic logic ctr_says_taken(input ctr_e c);
        return (c == CT_WEAK_T) || (c == CT_STRONG_T);
    endfunction

endpackage

// File: rtl/bpred_btb.sv
module bpred_btb
    import bpred_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int ENTRIES = 128
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] lk_pc,
    output logic              lk_hit,
    output ctr_e              lk_ctr,
    output logic [ADDR_W-1:0] lk_target,
    input  logic              up_en,
    input  br_kind_e          up_kind,
    input  logic [ADDR_W-1:0] up_pc,
    input  logic              up_taken,
    input  logic [ADDR_W-1:0] up_target
);
    localparam int IDX_W = $clog2(ENTRIES);
    localparam int TAG_W = ADDR_W - IDX_W;

    logic [ENTRIES-1:0] valid_q;
    logic [TAG_W-1:0]   tag_q [ENTRIES];
    logic [ADDR_W-1:0]  tgt_q [ENTRIES];
    ctr_e               ctr_q [ENTRIES];

    logic [IDX_W-1:0]  u_idx, l_idx;
    logic [TAG_W-1:0]  u_tag, l_tag;
    logic              u_hit;
    logic              wr_en;
    logic [ADDR_W-1:0] wr_tgt;
    ctr_e              wr_ctr;

    assign u_idx = up_pc[IDX_W-1:0];
    assign u_tag = up_pc[ADDR_W-1:IDX_W];
    assign l_idx = lk_pc[IDX_W-1:0];
    assign l_tag = lk_pc[ADDR_W-1:IDX_W];
    assign u_hit = valid_q[u_idx] && (tag_q[u_idx] == u_tag);

    // Resolution: train on hit, allocate weakly-taken on a taken miss
    always_comb begin
        wr_en  = 1'b0;
        wr_tgt = tgt_q[u_idx];
        wr_ctr = ctr_q[u_idx];
        if (up_en && (up_kind != BK_RET)) begin
            if (u_hit) begin
                wr_en  = 1'b1;
                wr_ctr = ctr_step(ctr_q[u_idx], up_taken);
                if (up_taken) begin
                    wr_tgt = up_target;
                end
            end else if (up_taken) begin
                wr_en  = 1'b1;
                wr_ctr = CT_WEAK_T;
                wr_tgt = up_target;
            end
        end
    end

    // Lookup, with the same-cycle write taking priority
    always_comb begin
        if (wr_en && (u_idx == l_idx)) begin
            lk_hit    = (u_tag == l_tag);
            lk_ctr    = wr_ctr;
            lk_target = wr_tgt;
        end else begin
            lk_hit    = valid_q[l_idx] && (tag_q[l_idx] == l_tag);
            lk_ctr    = ctr_q[l_idx];
            lk_target = tgt_q[l_idx];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
        end else if (wr_en) begin
            valid_q[u_idx] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            tag_q[u_idx] <= u_tag;
            tgt_q[u_idx] <= wr_tgt;
            ctr_q[u_idx] <= wr_ctr;
        end
    end

endmodule

// File: rtl/bpred_ras.sv
module bpred_ras #(
    parameter int ADDR_W = 32,
    parameter int DEPTH  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [ADDR_W-1:0] push_addr,
    input  logic              pop,
    output logic              top_valid,
    output logic [ADDR_W-1:0] top_addr
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);

    logic [ADDR_W-1:0] mem_q [DEPTH];
    logic [PTR_W-1:0]  wp_q, top_idx, wp_inc;
    logic [CNT_W-1:0]  cnt_q;

    assign top_idx   = (wp_q == '0) ? LAST : wp_q - 1'b1;
    assign wp_inc    = (wp_q == LAST) ? '0 : wp_q + 1'b1;
    assign top_valid = (cnt_q != '0);
    assign top_addr  = mem_q[top_idx];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp_q  <= '0;
            cnt_q <= '0;
        end else if (push) begin
            wp_q <= wp_inc;
            if (cnt_q != FULL) begin
                cnt_q <= cnt_q + 1'b1;
            end
        end else if (pop && top_valid) begin
            wp_q  <= top_idx;
            cnt_q <= cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (push) begin
            mem_q[wp_q] <= push_addr;
        end
    end

endmodule

// File: rtl/bpred_flush_fsm.sv
module bpred_flush_fsm
    import bpred_pkg::*;
#(
    parameter int FLUSH_CYC = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic mispredict_i,
    output logic busy_o
);
    localparam int CW = $clog2(FLUSH_CYC + 1);
    localparam logic [CW-1:0] RELOAD = CW'(FLUSH_CYC - 1);

    flush_state_e st_q, st_d;
    logic [CW-1:0] cnt_q, cnt_d;

    always_comb begin
        st_d  = st_q;
        cnt_d = cnt_q;
        unique case (st_q)
            FL_IDLE: begin
                if (mispredict_i) begin
                    st_d  = FL_DRAIN;
                    cnt_d = RELOAD;
                end
            end
            FL_DRAIN: begin
                if (mispredict_i) begin
                    cnt_d = RELOAD;
                end else if (cnt_q == '0) begin
                    st_d = FL_IDLE;
                end else begin
                    cnt_d = cnt_q - 1'b1;
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= FL_IDLE;
            cnt_q <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
        end
    end

    always_comb begin
        busy_o = (st_q == FL_DRAIN);
    end

endmodule

// File: rtl/bpred_top.sv
module bpred_top
    import bpred_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int ENTRIES   = 128,
    parameter int RAS_DEPTH = 8,
    parameter int FLUSH_CYC = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lk_valid,
    input  logic [ADDR_W-1:0] lk_pc,
    input  logic [1:0]        lk_kind,
    input  logic [ADDR_W-1:0] lk_next_pc,
    output logic              pred_hit,
    output logic              pred_taken,
    output logic [ADDR_W-1:0] pred_target,
    input  logic              up_valid,
    input  logic [ADDR_W-1:0] up_pc,
    input  logic [1:0]        up_kind,
    input  logic              up_taken,
    input  logic [ADDR_W-1:0] up_target,
    input  logic              up_pred_taken,
    input  logic [ADDR_W-1:0] up_pred_target,
    output logic              mispredict,
    output logic              flush_busy
);
    br_kind_e          lk_k, up_k;
    logic              lk_act;
    logic              btb_hit;
    ctr_e              btb_ctr;
    logic [ADDR_W-1:0] btb_tgt;
    logic              ras_valid;
    logic [ADDR_W-1:0] ras_top;

    assign lk_k   = br_kind_e'(lk_kind);
    assign up_k   = br_kind_e'(up_kind);
    assign lk_act = lk_valid && !flush_busy;

    assign mispredict = up_valid &&
        ((up_taken != up_pred_taken) || (up_taken && (up_target != up_pred_target)));

    bpred_btb #(.ADDR_W(ADDR_W), .ENTRIES(ENTRIES)) u_btb (
        .clk       (clk),
        .rst_n     (rst_n),
        .lk_pc     (lk_pc),
        .lk_hit    (btb_hit),
        .lk_ctr    (btb_ctr),
        .lk_target (btb_tgt),
        .up_en     (up_valid),
        .up_kind   (up_k),
        .up_pc     (up_pc),
        .up_taken  (up_taken),
        .up_target (up_target)
    );

    bpred_ras #(.ADDR_W(ADDR_W), .DEPTH(RAS_DEPTH)) u_ras (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (lk_act && (lk_k == BK_CALL)),
        .push_addr (lk_next_pc),
        .pop       (lk_act && (lk_k == BK_RET)),
        .top_valid (ras_valid),
        .top_addr  (ras_top)
    );

    bpred_flush_fsm #(.FLUSH_CYC(FLUSH_CYC)) u_flush (
        .clk          (clk),
        .rst_n        (rst_n),
        .mispredict_i (mispredict),
        .busy_o       (flush_busy)
    );

    always_comb begin
        pred_hit    = 1'b0;
        pred_taken  = 1'b0;
        pred_target = '0;
        if (lk_act) begin
            if (lk_k == BK_RET) begin
                if (ras_valid) begin
                    pred_taken  = 1'b1;
                    pred_target = ras_top;
                end
            end else if (btb_hit) begin
                pred_hit    = 1'b1;
                pred_taken  = (lk_k == BK_COND) ? ctr_says_taken(btb_ctr) : 1'b1;
                pred_target = pred_taken ? btb_tgt : '0;
            end
        end
    end

endmodule

// File: rtl/bpred_chk.sv
module bpred_chk #(
    parameter int FLUSH_CYC = 5
) (
    input logic       clk,
    input logic       rst_n,
    input logic       lk_valid,
    input logic [1:0] lk_kind,
    input logic       pred_hit,
    input logic       pred_taken,
    input logic       mispredict,
    input logic       flush_busy
);
    localparam int RW = $clog2(FLUSH_CYC + 2);
    logic [RW-1:0] run_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q <= '0;
        end else if (mispredict) begin
            run_q <= '0;
        end else if (flush_busy && (run_q < RW'(FLUSH_CYC))) begin
            run_q <= run_q + 1'b1;
        end
    end

    // R9
    mis_starts_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mispredict |=> flush_busy);

    // R9
    flush_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flush_busy) |-> $past(mispredict));

    // R9
    flush_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush_busy |-> (run_q < RW'(FLUSH_CYC)));

    // R9
    flush_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush_busy |-> (!pred_hit && !pred_taken));

    // R2
    cond_miss_nt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid && (lk_kind == 2'b00) && !pred_hit) |-> !pred_taken);

    // R5
    uncond_hit_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid && !flush_busy && pred_hit && (lk_kind inside {2'b01, 2'b10})) |-> pred_taken);

    // R10
    ret_no_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid && (lk_kind == 2'b11)) |-> !pred_hit);

endmodule

bind bpred_top bpred_chk #(.FLUSH_CYC(FLUSH_CYC)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .lk_valid   (lk_valid),
    .lk_kind    (lk_kind),
    .pred_hit   (pred_hit),
    .pred_taken (pred_taken),
    .mispredict (mispredict),
    .flush_busy (flush_busy)
);

// File: tb/bpred_top_tb.sv
`timescale 1ns/1ps
module bpred_top_tb;
    localparam int AW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          lk_valid = 1'b0;
    logic [AW-1:0] lk_pc = '0;
    logic [1:0]    lk_kind = '0;
    logic [AW-1:0] lk_next_pc = '0;
    logic          pred_hit, pred_taken;
    logic [AW-1:0] pred_target;
    logic          up_valid = 1'b0;
    logic [AW-1:0] up_pc = '0;
    logic [1:0]    up_kind = '0;
    logic          up_taken = 1'b0;
    logic [AW-1:0] up_target = '0;
    logic          up_pred_taken = 1'b0;
    logic [AW-1:0] up_pred_target = '0;
    logic          mispredict, flush_busy;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    logic          s_hit, s_tk, s_mis;
    logic [AW-1:0] s_tgt;

    always #10 clk = ~clk;

    bpred_top #(.ADDR_W(AW), .ENTRIES(16), .RAS_DEPTH(4), .FLUSH_CYC(5)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .lk_valid(lk_valid), .lk_pc(lk_pc), .lk_kind(lk_kind), .lk_next_pc(lk_next_pc),
        .pred_hit(pred_hit), .pred_taken(pred_taken), .pred_target(pred_target),
        .up_valid(up_valid), .up_pc(up_pc), .up_kind(up_kind), .up_taken(up_taken),
        .up_target(up_target), .up_pred_taken(up_pred_taken), .up_pred_target(up_pred_target),
        .mispredict(mispredict), .flush_busy(flush_busy)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic summary();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    endtask

    task automatic settle();
        @(negedge clk);
        while (flush_busy) @(negedge clk);
    endtask

    task automatic upd(input logic [AW-1:0] pc, input logic [1:0] k, input logic tk,
                       input logic [AW-1:0] tgt, input logic ptk, input logic [AW-1:0] ptgt,
                       input bit wait_flush);
        @(negedge clk);
        up_valid = 1; up_pc = pc; up_kind = k; up_taken = tk; up_target = tgt;
        up_pred_taken = ptk; up_pred_target = ptgt;
        #5 s_mis = mispredict;
        @(posedge clk);
        #1 up_valid = 0;
        if (wait_flush) settle();
    endtask

    task automatic look(input logic [AW-1:0] pc, input logic [1:0] k, input logic [AW-1:0] nxt);
        @(negedge clk);
        lk_valid = 1; lk_pc = pc; lk_kind = k; lk_next_pc = nxt;
        #5 s_hit = pred_hit; s_tk = pred_taken; s_tgt = pred_target;
        @(posedge clk);
        #1 lk_valid = 0;
    endtask

    task automatic t_reset();
        look(16'h0010, 2'b00, 16'h0);
        chk("R1 hit after reset", s_hit, 0);
        chk("R1 taken after reset", s_tk, 0);
        chk("R1 flush_busy after reset", flush_busy, 0);
        look(16'h0020, 2'b11, 16'h0);
        chk("R1 return on empty stack", s_tk, 0);
    endtask

    task automatic t_miss_nt();
        look(16'h0123, 2'b00, 16'h0);
        chk("R2 cond miss taken", s_tk, 0);
        chk("R2 cond miss target", s_tgt, 0);
        upd(16'h0123, 2'b00, 0, 16'h0, 0, 16'h0, 1);
        chk("R8 correct not-taken gives no mispredict", s_mis, 0);
        look(16'h0123, 2'b00, 16'h0);
        chk("R7 not-taken miss allocates nothing", s_hit, 0);
    endtask

    task automatic t_alloc_train();
        int n;
        upd(16'h0123, 2'b00, 1, 16'h4000, 0, 16'h0, 0);
        chk("R8 direction mismatch flags mispredict", s_mis, 1);
        n = 0;
        @(negedge clk);
        while (flush_busy && n < 20) begin n++; @(negedge clk); end
        chk("R9 flush window length", n, 5);
        look(16'h0123, 2'b00, 16'h0);
        chk("R3 allocated entry hits", s_hit, 1);
        chk("R3 weakly-taken predicts taken", s_tk, 1);
        chk("R3 target stored", s_tgt, 16'h4000);
        upd(16'h0123, 2'b00, 1, 16'h4000, 1, 16'h4000, 1);
        chk("R8 correct taken gives no mispredict", s_mis, 0);
        upd(16'h0123, 2'b00, 1, 16'h4000, 1, 16'h4004, 1);
        chk("R8 target mismatch flags mispredict", s_mis, 1);
        upd(16'h0123, 2'b00, 0, 16'h0, 1, 16'h4000, 1);
        look(16'h0123, 2'b00, 16'h0);
        chk("R4 strong taken needs two not-taken", s_tk, 1);
        upd(16'h0123, 2'b00, 0, 16'h0, 1, 16'h4000, 1);
        look(16'h0123, 2'b00, 16'h0);
        chk("R3 flips to not taken", s_tk, 0);
        chk("R3 entry still hits", s_hit, 1);
    endtask

    task automatic t_saturate();
        for (int i = 0; i < 4; i++) upd(16'h0245, 2'b00, 1, 16'h2450, 0, 16'h0, 1);
        upd(16'h0245, 2'b00, 0, 16'h0, 1, 16'h2450, 1);
        look(16'h0245, 2'b00, 16'h0);
        chk("R4 saturates at strongly taken", s_tk, 1);
        for (int i = 0; i < 4; i++) upd(16'h0245, 2'b00, 0, 16'h0, 0, 16'h0, 1);
        upd(16'h0245, 2'b00, 1, 16'h2450, 0, 16'h0, 1);
        look(16'h0245, 2'b00, 16'h0);
        chk("R4 saturates at strongly not-taken", s_tk, 0);
    endtask

    task automatic t_alias();
        look(16'h1123, 2'b00, 16'h0);
        chk("R6 different tag same index misses", s_hit, 0);
        look(16'h0123, 2'b00, 16'h0);
        chk("R6 original entry still hits", s_hit, 1);
    endtask

    task automatic t_uncond();
        upd(16'h0307, 2'b01, 1, 16'h5555, 0, 16'h0, 1);
        look(16'h0307, 2'b01, 16'h0);
        chk("R5 jump hit taken", s_tk, 1);
        chk("R5 jump target", s_tgt, 16'h5555);
        look(16'h0307, 2'b10, 16'h0309);
        chk("R5 call hit taken", s_tk, 1);
        look(16'h0300, 2'b11, 16'h0);
        chk("R10 return gets call address", s_tgt, 16'h0309);
        upd(16'h0307, 2'b01, 1, 16'h6666, 1, 16'h5555, 1);
        look(16'h0307, 2'b01, 16'h0);
        chk("R13 target replaced", s_tgt, 16'h6666);
    endtask

    task automatic t_flush_gate();
        upd(16'h0388, 2'b00, 1, 16'h3880, 0, 16'h0, 0);
        look(16'h0307, 2'b01, 16'h0);
        chk("R9 lookup during flush hit", s_hit, 0);
        chk("R9 lookup during flush taken", s_tk, 0);
        look(16'h0310, 2'b10, 16'h7777);
        settle();
        look(16'h0320, 2'b11, 16'h0);
        chk("R9 call during flush pushed nothing", s_tk, 0);
    endtask

    task automatic t_ras();
        look(16'h0400, 2'b10, 16'h1000);
        look(16'h0410, 2'b10, 16'h2000);
        look(16'h0420, 2'b11, 16'h0);
        chk("R10 first return", s_tgt, 16'h2000);
        chk("R10 return taken", s_tk, 1);
        chk("R10 return no hit", s_hit, 0);
        look(16'h0430, 2'b11, 16'h0);
        chk("R10 second return", s_tgt, 16'h1000);
        look(16'h0440, 2'b11, 16'h0);
        chk("R11 underflow not taken", s_tk, 0);
        for (int i = 1; i <= 5; i++) look(16'h0500, 2'b10, 16'(16'h00A0 + i));
        for (int i = 5; i >= 2; i--) begin
            look(16'h0510, 2'b11, 16'h0);
            chk("R11 overflow pop order", s_tgt, 16'(16'h00A0 + i));
        end
        look(16'h0520, 2'b11, 16'h0);
        chk("R11 oldest was dropped", s_tk, 0);
    endtask

    task automatic t_bypass();
        @(negedge clk);
        up_valid = 1; up_pc = 16'h034A; up_kind = 2'b00; up_taken = 1;
        up_target = 16'h3210; up_pred_taken = 0; up_pred_target = 16'h0;
        lk_valid = 1; lk_pc = 16'h034A; lk_kind = 2'b00; lk_next_pc = 16'h0;
        #5;
        chk("R12 same-cycle hit", pred_hit, 1);
        chk("R12 same-cycle taken", pred_taken, 1);
        chk("R12 same-cycle target", pred_target, 16'h3210);
        @(posedge clk);
        #1 up_valid = 0; lk_valid = 0;
        settle();
    endtask

    initial begin
        #(20 * 100000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        t_reset();
        t_miss_nt();
        t_alloc_train();
        t_saturate();
        t_alias();
        t_uncond();
        t_flush_gate();
        t_ras();
        t_bypass();
        summary();
    end

endmodule